// File: doc/BRIEF.md
# SCSI Controller Interrupt Aggregator

This block gathers the interrupt sources of a script-driven SCSI host controller into one level-sensitive interrupt line. It has three groups of sources. One group holds DMA and script-engine events. The other two groups hold SCSI bus events, named group 0 and group 1. Each group keeps a sticky status byte and an enable byte. A summary byte reports which groups hold pending events and whether the software interrupt flag is set.

The block also owns the script-running flag of the script processor. A start pulse sets the flag. A DMA event always clears it. A SCSI event clears it when one of two things is true: the event is fatal, or it is a non-fatal event whose enable bit is set. A selection timeout is the exception and never stops the processor when it arrives.

Every output comes from a register. Each output reflects the inputs sampled at the clock edge just before it.

Top module: `scsi_irq_aggregator`

## Requirements
- R1: While `rst` is high at a clock edge, the following all read zero after that edge: the three status bytes, the three enable bytes, `summary`, `irq` and `script_run`.
- R2: Status bits are sticky and lie at the same positions as the event bits that set them. A group's clear strobe zeroes that group. If a clear and an event reach the same group in the same cycle, the status holds exactly the new event bits.
- R3: Each enable write strobe loads its data into the matching enable byte, and the enable byte keeps that value until the next write to it.
- R4: The bits of `summary` are defined as follows:
  - Bit 0 is 1 exactly when the DMA status is nonzero.
  - Bit 1 is 1 exactly when either SCSI status byte is nonzero.
  - Bit 2 follows `sw_int`.
  - Bits 7:3 read zero.
- R5: `irq` is 1 exactly when at least one of these holds:
  - the DMA status ANDed with its enable is nonzero;
  - SCSI status 0 ANDed with its enable is nonzero;
  - SCSI status 1 ANDed with its enable is nonzero;
  - `sw_int` was high.
- R6: A cycle with `scsi_evt_valid` high clears `script_run` in either of these cases:
  - The merged group-0 status has a set bit that is either fatal or enabled. The non-fatal bits of group 0 are 0x10, 0x20 and 0x40; all other group-0 bits are fatal.
  - The merged group-1 status has a set bit, other than 0x04, that is either fatal or enabled. The non-fatal bits of group 1 are 0x01 and 0x02.

  The enables used are the values written in that same cycle, when there is such a write.
- R7: Group-1 bit 0x04 (selection timeout) never clears `script_run`, whatever its enable bit says.
- R8: A cycle with `dma_evt_valid` high clears `script_run`, whatever the enables say.
- R9: `run_start` sets `script_run`. A halt from R6 or R8 in the same cycle wins over the start.
- R10: Without an event, a start pulse or a reset, `script_run` holds its value.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_evt_valid | input | 1 | DMA event pulse |
| dma_evt_bits | input | 8 | DMA event bits |
| scsi_evt_valid | input | 1 | SCSI event pulse for both SCSI groups |
| scsi_evt0_bits | input | 8 | SCSI group-0 event bits |
| scsi_evt1_bits | input | 8 | SCSI group-1 event bits |
| dma_clr | input | 1 | Clear strobe for the DMA status |
| scsi0_clr | input | 1 | Clear strobe for SCSI status 0 |
| scsi1_clr | input | 1 | Clear strobe for SCSI status 1 |
| dma_en_we | input | 1 | DMA enable write strobe |
| scsi0_en_we | input | 1 | SCSI enable 0 write strobe |
| scsi1_en_we | input | 1 | SCSI enable 1 write strobe |
| en_wdata | input | 8 | Write data shared by the enable writes |
| sw_int | input | 1 | Software interrupt flag |
| run_start | input | 1 | Start pulse for the script processor |
| irq | output | 1 | Level-sensitive interrupt line |
| script_run | output | 1 | Script-running flag |
| summary | output | 8 | Summary status byte |
| dma_stat | output | 8 | DMA status |
| scsi_stat0 | output | 8 | SCSI status 0 |
| scsi_stat1 | output | 8 | SCSI status 1 |
| dma_en | output | 8 | DMA enable |
| scsi_en0 | output | 8 | SCSI enable 0 |
| scsi_en1 | output | 8 | SCSI enable 1 |

## Verification
Two pairs of functions can fall in the same cycle:
- a halt decision and a start pulse;
- a status clear and a new event on the same group.

The random stimulus raises start pulses, events, clears and enable writes independently, so all of these overlaps occur many times. Directed cases also force each pair on purpose. The bench judges every cycle against a model that applies the clear before the event, and a halt before the start.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  localparam int STAT_W   = 8;
  localparam int N_GROUPS = 3;
  localparam int G_DMA    = 0;
  localparam int G_SCSI0  = 1;
  localparam int G_SCSI1  = 2;

  localparam logic [STAT_W-1:0] SCSI0_SOFT    = 8'h70;
  localparam logic [STAT_W-1:0] SCSI1_SOFT    = 8'h03;
  localparam logic [STAT_W-1:0] SCSI1_SEL_TMO = 8'h04;

  localparam int SUM_DMA  = 0;
  localparam int SUM_SCSI = 1;
  localparam int SUM_SW   = 2;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/sirq_status_bank.sv
module sirq_status_bank #(
  parameter int W  = 8,
  parameter int NG = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NG-1:0]        evt_valid,
  input  logic [NG-1:0][W-1:0] evt_bits,
  input  logic [NG-1:0]        clr,
  input  logic [NG-1:0]        en_we,
  input  logic [W-1:0]         en_wdata,
  output logic [NG-1:0][W-1:0] stat_q,
  output logic [NG-1:0][W-1:0] en_q,
  output logic [NG-1:0][W-1:0] stat_nx,
  output logic [NG-1:0][W-1:0] en_nx
);
  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [W-1:0] kept;
    logic [W-1:0] incoming;

    always_comb begin
      kept       = clr[g] ? '0 : stat_q[g];
      incoming   = evt_valid[g] ? evt_bits[g] : '0;
      stat_nx[g] = kept | incoming;
      en_nx[g]   = en_we[g] ? en_wdata : en_q[g];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stat_q[g] <= '0;
        en_q[g]   <= '0;
      end else begin
        stat_q[g] <= stat_nx[g];
        en_q[g]   <= en_nx[g];
      end
    end
  end
endmodule

// File: rtl/sirq_halt_ctrl.sv
module sirq_halt_ctrl
  import scsi_irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dma_evt,
  input  logic         scsi_evt,
  input  logic [W-1:0] s0_nx,
  input  logic [W-1:0] s1_nx,
  input  logic [W-1:0] e0_nx,
  input  logic [W-1:0] e1_nx,
  input  logic         start,
  output logic         run_q
);
  logic [W-1:0] mask0;
  logic [W-1:0] mask1;
  logic         scsi_halt;
  logic         halt;

  always_comb begin
    mask0     = e0_nx | ~W'(SCSI0_SOFT);
    mask1     = (e1_nx | ~W'(SCSI1_SOFT)) & ~W'(SCSI1_SEL_TMO);
    scsi_halt = scsi_evt && (((s0_nx & mask0) != '0) || ((s1_nx & mask1) != '0));
    halt      = dma_evt || scsi_halt;
  end

  always_ff @(posedge clk) begin
    if (rst)        run_q <= 1'b0;
    else if (halt)  run_q <= 1'b0;
    else if (start) run_q <= 1'b1;
  end
endmodule

// File: rtl/sirq_summary.sv
module sirq_summary
  import scsi_irq_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int NG = N_GROUPS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NG-1:0][W-1:0] stat_nx,
  input  logic [NG-1:0][W-1:0] en_nx,
  input  logic                 sw_int,
  output logic [W-1:0]         summary_q,
  output logic                 irq_q
);
  logic [NG-1:0] grp_hit;
  logic [W-1:0]  sum_nx;

  for (genvar g = 0; g < NG; g++) begin : g_hit
    assign grp_hit[g] = |(stat_nx[g] & en_nx[g]);
  end

  always_comb begin
    sum_nx           = '0;
    sum_nx[SUM_DMA]  = |stat_nx[G_DMA];
    sum_nx[SUM_SCSI] = (|stat_nx[G_SCSI0]) | (|stat_nx[G_SCSI1]);
    sum_nx[SUM_SW]   = sw_int;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      summary_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      summary_q <= sum_nx;
      irq_q     <= (|grp_hit) | sw_int;
    end
  end
endmodule

// File: rtl/scsi_irq_aggregator.sv
module scsi_irq_aggregator
  import scsi_irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dma_evt_valid,
  input  logic [W-1:0] dma_evt_bits,
  input  logic         scsi_evt_valid,
  input  logic [W-1:0] scsi_evt0_bits,
  input  logic [W-1:0] scsi_evt1_bits,
  input  logic         dma_clr,
  input  logic         scsi0_clr,
  input  logic         scsi1_clr,
  input  logic         dma_en_we,
  input  logic         scsi0_en_we,
  input  logic         scsi1_en_we,
  input  logic [W-1:0] en_wdata,
  input  logic         sw_int,
  input  logic         run_start,
  output logic         irq,
  output logic         script_run,
  output logic [W-1:0] summary,
  output logic [W-1:0] dma_stat,
  output logic [W-1:0] scsi_stat0,
  output logic [W-1:0] scsi_stat1,
  output logic [W-1:0] dma_en,
  output logic [W-1:0] scsi_en0,
  output logic [W-1:0] scsi_en1
);
  localparam int NG = N_GROUPS;

  logic [NG-1:0]        evt_valid;
  logic [NG-1:0][W-1:0] evt_bits;
  logic [NG-1:0]        clr;
  logic [NG-1:0]        en_we;
  logic [NG-1:0][W-1:0] stat_q;
  logic [NG-1:0][W-1:0] en_q;
  logic [NG-1:0][W-1:0] stat_nx;
  logic [NG-1:0][W-1:0] en_nx;

  always_comb begin
    evt_valid         = {scsi_evt_valid, scsi_evt_valid, dma_evt_valid};
    evt_bits[G_DMA]   = dma_evt_bits;
    evt_bits[G_SCSI0] = scsi_evt0_bits;
    evt_bits[G_SCSI1] = scsi_evt1_bits;
    clr               = {scsi1_clr, scsi0_clr, dma_clr};
    en_we             = {scsi1_en_we, scsi0_en_we, dma_en_we};
  end

  sirq_status_bank #(.W(W), .NG(NG)) u_bank (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_bits(evt_bits),
    .clr(clr), .en_we(en_we), .en_wdata(en_wdata),
    .stat_q(stat_q), .en_q(en_q), .stat_nx(stat_nx), .en_nx(en_nx)
  );

  sirq_halt_ctrl #(.W(W)) u_halt (
    .clk(clk), .rst(rst), .dma_evt(dma_evt_valid), .scsi_evt(scsi_evt_valid),
    .s0_nx(stat_nx[G_SCSI0]), .s1_nx(stat_nx[G_SCSI1]),
    .e0_nx(en_nx[G_SCSI0]), .e1_nx(en_nx[G_SCSI1]),
    .start(run_start), .run_q(script_run)
  );

  sirq_summary #(.W(W), .NG(NG)) u_sum (
    .clk(clk), .rst(rst), .stat_nx(stat_nx), .en_nx(en_nx),
    .sw_int(sw_int), .summary_q(summary), .irq_q(irq)
  );

  assign dma_stat   = stat_q[G_DMA];
  assign scsi_stat0 = stat_q[G_SCSI0];
  assign scsi_stat1 = stat_q[G_SCSI1];
  assign dma_en     = en_q[G_DMA];
  assign scsi_en0   = en_q[G_SCSI0];
  assign scsi_en1   = en_q[G_SCSI1];
endmodule

// File: rtl/scsi_irq_aggregator_chk.sv
module scsi_irq_aggregator_chk (
  input logic       clk,
  input logic       rst,
  input logic       dma_evt_valid,
  input logic       scsi_evt_valid,
  input logic [7:0] scsi_evt0_bits,
  input logic [7:0] scsi_evt1_bits,
  input logic       dma_clr,
  input logic       run_start,
  input logic       irq,
  input logic       script_run,
  input logic [7:0] summary,
  input logic [7:0] dma_stat,
  input logic [7:0] scsi_stat0,
  input logic [7:0] scsi_stat1,
  input logic [7:0] dma_en,
  input logic [7:0] scsi_en0,
  input logic [7:0] scsi_en1
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dma_stat == 8'h00 && scsi_stat0 == 8'h00 && scsi_stat1 == 8'h00 &&
             summary == 8'h00 && !irq && !script_run));

  // R2
  a_r2_sticky_dma: assert property (@(posedge clk) disable iff (rst)
    !dma_clr |=> ((dma_stat & $past(dma_stat)) == $past(dma_stat)));

  // R4
  a_r4_summary_groups: assert property (@(posedge clk) disable iff (rst)
    (summary[0] == (dma_stat != 8'h00)) &&
    (summary[1] == ((scsi_stat0 | scsi_stat1) != 8'h00)) &&
    (summary[7:3] == 5'd0));

  // R5
  a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (((dma_stat & dma_en) != 8'h00) || ((scsi_stat0 & scsi_en0) != 8'h00) ||
            ((scsi_stat1 & scsi_en1) != 8'h00) || summary[2]));

  // R8
  a_r8_dma_halts: assert property (@(posedge clk) disable iff (rst)
    dma_evt_valid |=> !script_run);

  // R7
  a_r7_seltmo_no_halt: assert property (@(posedge clk) disable iff (rst)
    (scsi_evt_valid && !dma_evt_valid && scsi_evt0_bits == 8'h00 &&
     (scsi_evt1_bits & 8'hFB) == 8'h00 && summary[1] == 1'b0 && script_run)
    |=> script_run);

  // R10
  a_r10_run_holds: assert property (@(posedge clk) disable iff (rst)
    (!dma_evt_valid && !scsi_evt_valid && !run_start) |=> $stable(script_run));
endmodule

bind scsi_irq_aggregator scsi_irq_aggregator_chk u_chk (
  .clk(clk), .rst(rst), .dma_evt_valid(dma_evt_valid), .scsi_evt_valid(scsi_evt_valid),
  .scsi_evt0_bits(scsi_evt0_bits), .scsi_evt1_bits(scsi_evt1_bits),
  .dma_clr(dma_clr), .run_start(run_start), .irq(irq), .script_run(script_run),
  .summary(summary), .dma_stat(dma_stat), .scsi_stat0(scsi_stat0),
  .scsi_stat1(scsi_stat1), .dma_en(dma_en), .scsi_en0(scsi_en0), .scsi_en1(scsi_en1)
);

// File: tb/tb_scsi_irq_aggregator.sv
`timescale 1ns/1ps
module tb_scsi_irq_aggregator;
  logic clk = 1'b0;
  logic rst;
  logic dma_evt_valid, scsi_evt_valid;
  logic [7:0] dma_evt_bits, scsi_evt0_bits, scsi_evt1_bits;
  logic dma_clr, scsi0_clr, scsi1_clr;
  logic dma_en_we, scsi0_en_we, scsi1_en_we;
  logic [7:0] en_wdata;
  logic sw_int, run_start;
  logic irq, script_run;
  logic [7:0] summary, dma_stat, scsi_stat0, scsi_stat1, dma_en, scsi_en0, scsi_en1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_ds, m_s0, m_s1, m_de, m_e0, m_e1, m_sum;
  logic m_irq, m_run;

  always #2.5 clk = ~clk;

  scsi_irq_aggregator dut (.*);

  function automatic logic halt_of(input logic dv, input logic sv,
                                   input logic [7:0] s0, input logic [7:0] s1,
                                   input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] f0, f1;
    f0 = s0 & (e0 | 8'h8F);
    f1 = s1 & (e1 | 8'hFC) & 8'hFB;
    return dv || (sv && (f0 != 0 || f1 != 0));
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dma_evt_valid = 0; scsi_evt_valid = 0;
    dma_evt_bits = 0; scsi_evt0_bits = 0; scsi_evt1_bits = 0;
    dma_clr = 0; scsi0_clr = 0; scsi1_clr = 0;
    dma_en_we = 0; scsi0_en_we = 0; scsi1_en_we = 0;
    en_wdata = 0; run_start = 0;
  endtask

  // update model from current inputs, clock once, compare at negedge
  task automatic step();
    logic [7:0] ns0, ns1, nds, ne0, ne1, nde;
    logic h;
    nds = (dma_clr ? 8'h00 : m_ds) | (dma_evt_valid ? dma_evt_bits : 8'h00);
    ns0 = (scsi0_clr ? 8'h00 : m_s0) | (scsi_evt_valid ? scsi_evt0_bits : 8'h00);
    ns1 = (scsi1_clr ? 8'h00 : m_s1) | (scsi_evt_valid ? scsi_evt1_bits : 8'h00);
    nde = dma_en_we ? en_wdata : m_de;
    ne0 = scsi0_en_we ? en_wdata : m_e0;
    ne1 = scsi1_en_we ? en_wdata : m_e1;
    h = halt_of(dma_evt_valid, scsi_evt_valid, ns0, ns1, ne0, ne1);
    m_run = h ? 1'b0 : (run_start ? 1'b1 : m_run);
    m_ds = nds; m_s0 = ns0; m_s1 = ns1; m_de = nde; m_e0 = ne0; m_e1 = ne1;
    m_sum = {5'd0, sw_int, (ns0 | ns1) != 0, nds != 0};
    m_irq = ((nds & nde) != 0) || ((ns0 & ne0) != 0) || ((ns1 & ne1) != 0) || sw_int;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "dma_stat", dma_stat, m_ds);
    chk("R2", "scsi_stat0", scsi_stat0, m_s0);
    chk("R2", "scsi_stat1", scsi_stat1, m_s1);
    chk("R3", "dma_en", dma_en, m_de);
    chk("R3", "scsi_en0", scsi_en0, m_e0);
    chk("R3", "scsi_en1", scsi_en1, m_e1);
    chk("R4", "summary", summary, m_sum);
    chk("R5", "irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R6/R7/R8/R9/R10", "script_run", {7'd0, script_run}, {7'd0, m_run});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    idle_inputs(); sw_int = 0; rst = 1;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1", "dma_stat", dma_stat, 8'h00);
    chk("R1", "scsi_stat0", scsi_stat0, 8'h00);
    chk("R1", "scsi_stat1", scsi_stat1, 8'h00);
    chk("R1", "enables", dma_en | scsi_en0 | scsi_en1, 8'h00);
    chk("R1", "summary", summary, 8'h00);
    chk("R1", "irq/run", {6'd0, irq, script_run}, 8'h00);
    rst = 0;
    m_ds = 0; m_s0 = 0; m_s1 = 0; m_de = 0; m_e0 = 0; m_e1 = 0; m_sum = 0; m_irq = 0; m_run = 0;

    // R7: selection timeout, enabled, never halts
    en_wdata = 8'h04; scsi1_en_we = 1; run_start = 1; step(); idle_inputs();
    scsi_evt_valid = 1; scsi_evt1_bits = 8'h04; step(); idle_inputs();
    chk("R7", "run after sel-timeout", {7'd0, script_run}, 8'h01);
    chk("R5", "irq from enabled sel-timeout", {7'd0, irq}, 8'h01);

    // R6: non-fatal disabled keeps running, enabled halts
    scsi1_clr = 1; step(); idle_inputs();
    scsi_evt_valid = 1; scsi_evt0_bits = 8'h40; step(); idle_inputs();
    chk("R6", "run after disabled non-fatal", {7'd0, script_run}, 8'h01);
    scsi0_en_we = 1; en_wdata = 8'h40; scsi_evt_valid = 1; scsi_evt0_bits = 8'h20; step(); idle_inputs();
    chk("R6", "run after enable written with event", {7'd0, script_run}, 8'h00);
    // R6: fatal bit halts with enables zero
    scsi0_clr = 1; scsi0_en_we = 1; en_wdata = 0; run_start = 1; step(); idle_inputs();
    scsi_evt_valid = 1; scsi_evt1_bits = 8'h10; step(); idle_inputs();
    chk("R6", "run after fatal group-1 event", {7'd0, script_run}, 8'h00);

    // R8 + R9: dma event beats start in same cycle
    scsi1_clr = 1; run_start = 1; step(); idle_inputs();
    dma_evt_valid = 1; dma_evt_bits = 8'h04; run_start = 1; step(); idle_inputs();
    chk("R9", "halt beats start", {7'd0, script_run}, 8'h00);
    chk("R8", "dma status", dma_stat, 8'h04);

    // R2: clear and event same cycle
    dma_clr = 1; dma_evt_valid = 1; dma_evt_bits = 8'h81; step(); idle_inputs();
    chk("R2", "clear+event", dma_stat, 8'h81);

    // R4: software flag
    sw_int = 1; step(); sw_int = 0;
    chk("R4", "sw bit", summary & 8'h04, 8'h04);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      dma_evt_valid  = (r[2:0] == 0);
      scsi_evt_valid = (r[5:3] == 0);
      dma_evt_bits   = 8'($urandom());
      scsi_evt0_bits = 8'($urandom()) & {8{r[6]}};
      scsi_evt1_bits = 8'($urandom()) & 8'h17;
      dma_clr   = (r[10:8] == 0);
      scsi0_clr = (r[13:11] == 0);
      scsi1_clr = (r[16:14] == 0);
      dma_en_we   = (r[19:17] == 0);
      scsi0_en_we = (r[22:20] == 0);
      scsi1_en_we = (r[25:23] == 0);
      en_wdata  = 8'($urandom());
      sw_int    = (r[28:26] == 0);
      run_start = r[29] | r[30];
      step();
    end
    idle_inputs(); sw_int = 0;

    // R1: reset mid-run clears everything
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    chk("R1", "status after reset", dma_stat | scsi_stat0 | scsi_stat1, 8'h00);
    chk("R1", "run/irq after reset", {6'd0, irq, script_run}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule